// File: doc/BRIEF.md
# Chainable Serial Register Port

This block is a serial slave port that gives a host read and write access to a small bank of 16-bit registers. The host drives a serial clock, an active-low select and a data input. The block returns data on an output that has its own enable, so a pad can tri-state it. Every transaction opens with a 32-bit command word. The command carries a direction flag, an auto-increment flag and a register address. One or more 16-bit data words follow while select stays low.

While a device is not driving read data, its output repeats its input. Several devices can therefore sit on one serial chain. During the data words of a read, the output carries the addressed register instead. When auto-increment is set, one select window walks through consecutive registers.

No logic runs on the serial clock. The block samples serial clock, select and data input on a system clock that runs at least four times faster, through two-flop synchronisers. It acts on the edges it detects there. Because of this, the host must leave a short idle gap before the first read bit.

Top module: `serial_reg_port`

## Requirements
- R1: The command word is 32 bits, sent most significant bit first. Bit 31 set to 1 means read and 0 means write. Bit 30 set to 1 enables auto-increment. Bits ADDR_W-1..0 hold the register address. Bits 29..ADDR_W are ignored.
- R2: Data words are DATA_W (16) bits, sent MSB first, and are sampled on rising serial clock edges. On a write, the register is updated only when the 16th bit arrives.
- R3: During the whole command phase and during the data words of a write, `ser_out` equals `ser_in` delayed by two system clocks.
- R4: During the data words of a read, `ser_out` carries the addressed register MSB first. Each bit changes only after a falling serial clock edge and is valid before the next rising edge.
- R5: `ser_oe` is 0 while select is high and 1 while select is low. Each change takes effect after the two-stage synchroniser.
- R6: With auto-increment set, the address rises by one after each completed data word and wraps modulo 2^ADDR_W.
- R7: With auto-increment clear, every data word in the window uses the command's address.
- R8: Raising select mid-command or mid-word abandons the transaction without changing any register. The next select-low window starts with a fresh command.
- R9: Reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Active-low transaction select |
| ser_in | input | 1 | Serial data from the host or from the upstream device |
| ser_out | output | 1 | Echoed input, or read data during read words |
| ser_oe | output | 1 | Output enable for the ser_out pad driver |

## Verification
A wrong bit counter or phase flag shows up at the ports within one serial bit. The echo on `ser_out` breaks, or read data begins a bit early or late, and the next read-back word comes back shifted. A wrong address pointer stays hidden until that register is read back. For that reason every write is followed, sooner or later, by reads of the same address through both increment modes. An abort that leaks a partial word also stays hidden until the aborted address is read back.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic sel_n,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_oe
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int CNT_W = $clog2(CMD_W);

  logic [2:0] clk_q;
  logic [1:0] sel_q, din_q;
  logic sel, rise, fall, bit_in;

  logic [CMD_W-2:0]  sh;
  logic [CMD_W-1:0]  cmd;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr, cmd_addr;
  logic [DATA_W-1:0] tx;
  logic [DATA_W-1:0] regs [NREG];
  logic in_data, rd_op, ainc, last_cmd, last_dat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_q <= '0;
      sel_q <= '1;
      din_q <= '0;
    end else begin
      clk_q <= {clk_q[1:0], ser_clk};
      sel_q <= {sel_q[0], sel_n};
      din_q <= {din_q[0], ser_in};
    end

  assign sel      = ~sel_q[1];
  assign rise     = clk_q[1] & ~clk_q[2];
  assign fall     = ~clk_q[1] & clk_q[2];
  assign bit_in   = din_q[1];
  assign cmd      = {sh, bit_in};
  assign cmd_addr = cmd[ADDR_W-1:0];
  assign last_cmd = cnt == CNT_W'(CMD_W - 1);
  assign last_dat = cnt == CNT_W'(DATA_W - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      addr    <= '0;
      tx      <= '0;
      in_data <= 1'b0;
      rd_op   <= 1'b0;
      ainc    <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (!sel) begin
      cnt     <= '0;
      in_data <= 1'b0;
      rd_op   <= 1'b0;
    end else if (rise) begin
      sh <= cmd[CMD_W-2:0];
      if (!in_data) begin
        if (last_cmd) begin
          cnt     <= '0;
          in_data <= 1'b1;
          rd_op   <= cmd[CMD_W-1];
          ainc    <= cmd[CMD_W-2];
          addr    <= cmd_addr;
          tx      <= regs[cmd_addr];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (last_dat) begin
        cnt <= '0;
        if (!rd_op) regs[addr] <= cmd[DATA_W-1:0];
        if (ainc) addr <= addr + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (fall && in_data && rd_op) begin
      tx <= (cnt == '0) ? regs[addr] : {tx[DATA_W-2:0], 1'b0};
    end

  assign ser_out = (in_data && rd_op) ? tx[DATA_W-1] : bit_in;
  assign ser_oe  = sel;
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              ser_in,
  input logic              ser_out,
  input logic              ser_oe,
  input logic              sel,
  input logic              rise,
  input logic              fall,
  input logic              in_data,
  input logic              rd_op,
  input logic              ainc,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] tx
);
  logic word_done;
  assign word_done = sel && rise && in_data && (cnt == CNT_W'(DATA_W - 1));

  p_hiz_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_n, 2) && $past(sel_n, 3) && $past(sel_n, 4)) |-> !ser_oe);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_n, 2) && $past(sel_n, 3) && $past(sel_n, 4)) |-> (!in_data && cnt == '0));

  p_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && !(in_data && rd_op)) |-> ser_out == $past(ser_in, 2));

  p_tx_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && in_data && rd_op && !fall) |=> $stable(tx));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && ainc) |=> addr == ADDR_W'($past(addr) + 1'b1));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !ainc) |=> $stable(addr));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> cnt < CNT_W'(DATA_W));
endmodule

bind serial_reg_port serial_reg_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_in(ser_in),
  .ser_out(ser_out), .ser_oe(ser_oe), .sel(sel), .rise(rise), .fall(fall),
  .in_data(in_data), .rd_op(rd_op), .ainc(ainc), .addr(addr), .cnt(cnt), .tx(tx)
);

// File: tb/serial_reg_port_tb_top.sv
module serial_reg_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, ser_clk = 1'b0, sel_n = 1'b1, ser_in = 1'b0;
  logic ser_out, ser_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] mdl [16];
  logic [15:0] wd [8];

  serial_reg_port dut_i (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n),
                         .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mk_cmd(bit rd, bit ai, logic [3:0] a, logic [25:0] junk);
    return {rd, ai, junk, a};
  endfunction

  function automatic logic [3:0] exp_addr(logic [3:0] a, bit ai, int w);
    return ai ? 4'(a + w) : a;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic o);
    ser_in = b;
    repeat (HALF) @(negedge clk);
    o = ser_out;
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic select_on();
    @(negedge clk) sel_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(ser_oe === 1'b1, "R5 oe while selected", ser_oe, 1);
  endtask

  task automatic select_off();
    @(negedge clk);
    sel_n = 1'b1;
    ser_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_cmd(bit rd, bit ai, logic [3:0] a, logic [25:0] junk);
    logic [31:0] c;
    logic o;
    c = mk_cmd(rd, ai, a, junk);
    for (int i = 31; i >= 0; i--) begin
      xbit(c[i], o);
      if (i == 0 || i == 31) chk(o === c[i], "R3 command echo", o, c[i]);
    end
  endtask

  task automatic wr_txn(logic [3:0] a, bit ai, int n, logic [25:0] junk);
    logic o;
    bit ok;
    select_on();
    send_cmd(0, ai, a, junk);
    for (int w = 0; w < n; w++) begin
      ok = 1;
      for (int i = 15; i >= 0; i--) begin
        xbit(wd[w][i], o);
        if (o !== wd[w][i]) ok = 0;
      end
      chk(ok, "R3 write echo", ok, 1);
      mdl[exp_addr(a, ai, w)] = wd[w];
    end
    select_off();
  endtask

  task automatic rd_txn(logic [3:0] a, bit ai, int n, string tag);
    logic o;
    logic [15:0] got;
    logic [3:0] ea;
    select_on();
    send_cmd(1, ai, a, 26'($urandom));
    for (int w = 0; w < n; w++) begin
      for (int i = 15; i >= 0; i--) begin
        xbit(1'($urandom), o);
        got[i] = o;
      end
      ea = exp_addr(a, ai, w);
      chk(got === mdl[ea], tag, got, mdl[ea]);
    end
    select_off();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic o;
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    chk(ser_oe === 1'b0, "R5 oe in reset", ser_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(ser_oe === 1'b0, "R5 oe idle", ser_oe, 0);

    // R9: all registers zero after reset
    rd_txn(4'd0, 1, 8, "R9 reset value");
    rd_txn(4'd8, 1, 8, "R9 reset value");

    // R2/R4 single word
    wd[0] = 16'hA5C3;
    wr_txn(4'd2, 0, 1, '0);
    rd_txn(4'd2, 0, 1, "R2 R4 single word");

    // R1 ignored middle command bits
    wd[0] = 16'h1357;
    wr_txn(4'd3, 0, 1, '1);
    rd_txn(4'd3, 0, 1, "R1 ignored bits");
    rd_txn(4'd2, 0, 1, "R1 neighbour untouched");

    // R6 increment with wrap 14,15,0,1
    wd[0] = 16'h0E0E; wd[1] = 16'hF0F0; wd[2] = 16'h8001; wd[3] = 16'h7FFE;
    wr_txn(4'd14, 1, 4, 26'h2AAAAAA);
    rd_txn(4'd14, 1, 4, "R6 wrap burst");
    rd_txn(4'd0, 0, 1, "R6 wrapped word");

    // R7 no increment: last word stands, neighbour unchanged
    wd[0] = 16'h1111; wd[1] = 16'h2222; wd[2] = 16'hBEEF;
    wr_txn(4'd6, 0, 3, '0);
    rd_txn(4'd6, 0, 3, "R7 same address");
    rd_txn(4'd7, 0, 1, "R7 next untouched");

    // R8 abort mid data word
    select_on();
    send_cmd(0, 0, 4'd6, '0);
    for (int i = 0; i < 9; i++) xbit(1'($urandom), o);
    select_off();
    chk(ser_oe === 1'b0, "R5 oe after abort", ser_oe, 0);
    rd_txn(4'd6, 0, 1, "R8 partial word dropped");

    // R8 abort mid command, then a fresh transaction
    select_on();
    for (int i = 0; i < 10; i++) xbit(1'b1, o);
    select_off();
    wd[0] = 16'h4C4C;
    wr_txn(4'd9, 0, 1, '0);
    rd_txn(4'd9, 0, 1, "R8 fresh command after abort");

    // Random mix
    for (int t = 0; t < 40; t++) begin
      logic [3:0] a;
      bit ai;
      int n;
      a  = 4'($urandom);
      ai = 1'($urandom);
      n  = 1 + int'($urandom % 4);
      if ($urandom % 2) begin
        for (int w = 0; w < n; w++) wd[w] = 16'($urandom);
        wr_txn(a, ai, n, 26'($urandom));
      end else begin
        rd_txn(a, ai, n, ai ? "R6 random read" : "R7 random read");
      end
    end
    rd_txn(4'd0, 1, 8, "R2 final sweep");
    rd_txn(4'd8, 1, 8, "R2 final sweep");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule